// File: doc/BRIEF.md
# Iterative Radix-2 FFT Engine

This core computes a complex discrete Fourier transform of a fixed power-of-two length in place. One butterfly unit and one sample memory do all the work. While the core is idle, a host writes N complex samples in signed Q1.15 format through a load port. It then pulses `start` and waits for `done`. When `done` arrives, the host reads the spectrum back through a registered read port.

Internally a controller keeps a stage counter and a butterfly index. For each index it forms the two operand addresses and a twiddle-table address, reads both operands, and multiplies the second operand by the twiddle. It then writes the sum and the difference back to the same two locations, halved. The twiddle table is computed at elaboration from the transform length. Input goes in natural order and the spectrum comes out in bit-reversed order. Every result is scaled by 1/N.

Top module: `fft_iter_core`

## Requirements
- R1: While `busy` is low, a high `ld_en` at a clock edge stores {`ld_re`,`ld_im`} at `ld_addr`. A read address applied before an edge returns that word on `rd_re`/`rd_im` after that edge, so the read port has one cycle of latency.
- R2: In stage s (0 to log2N−1), butterfly index b pairs address `ia` with `ib = ia + (N >> (s+1))`. Here `ia` is b with a zero inserted at bit position log2N−1−s. The twiddle index is the bit-reversal over log2N−1 bits of b >> (log2N−1−s).
- R3: A transform runs log2N stages of N/2 butterflies, and each butterfly takes three cycles. `busy` rises on the edge that samples `start` while idle and stays high for exactly 3·log2N·N/2 cycles.
- R4: Each butterfly writes A+W·B to `ia` and A−W·B to `ib`. The twiddle for index k is W = round(32767·cos(2πk/N)) − j·round(32767·sin(2πk/N)).
- R5: The complex product W·B is formed at full precision and shifted right arithmetically by 15 bits, which rounds it toward minus infinity before the add and subtract.
- R6: Each sum and difference is shifted right arithmetically by one bit and saturated to the range −32768 to 32767.
- R7: `done` is a single-cycle pulse. It is high in the first cycle in which `busy` is low again after a transform and is never high twice in a row.
- R8: While `busy` is high, `ld_en` writes nothing and `rd_re`/`rd_im` keep their value whatever `rd_addr` does.
- R9: The spectrum is left in bit-reversed order: bin k is found at the address whose log2N bits are k reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| start | input | 1 | Begins a transform when sampled while idle |
| ld_en | input | 1 | Write strobe of the load port |
| ld_addr | input | LOG2N | Load address |
| ld_re | input | 16 | Real part to load, Q1.15 |
| ld_im | input | 16 | Imaginary part to load, Q1.15 |
| rd_addr | input | LOG2N | Unload address |
| rd_re | output | 16 | Registered real part read out |
| rd_im | output | 16 | Registered imaginary part read out |
| busy | output | 1 | High while a transform is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the core with LOG2N = 4, which gives 16 points and 96-cycle runs. At this size all four stage shapes occur: the first stage, where every twiddle is unity, up to the last stage, which visits every table entry. Because the bench model rounds and truncates the same way, the 16 words of each run can be compared bit for bit. An impulse, a constant, a single complex tone, pseudo-random full-scale data and an all-minimum input drive the truncation and saturation corners. During the random run, writes and read-address changes are injected while the core is busy.

// File: rtl/fft_pkg.sv
package fft_pkg;
  localparam int SW   = 16;
  localparam int FRAC = SW - 1;
  localparam int MAXV = (1 << (SW - 1)) - 1;

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } cplx_t;

  typedef struct packed {
    logic signed [SW:0] re;
    logic signed [SW:0] im;
  } prod_t;

  // reverse the low w bits of v
  function automatic int bitrev(input int v, input int w);
    int r;
    r = 0;
    for (int i = 0; i < 16; i++)
      if (i < w) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  // full-precision W*B, then floor to Q1.15 (one guard bit kept)
  function automatic prod_t cmul_floor(input cplx_t w, input cplx_t b);
    logic signed [2*SW:0] wr, wi, br, bi, pr, pi;
    prod_t o;
    wr = {{(SW+1){w.re[SW-1]}}, w.re};
    wi = {{(SW+1){w.im[SW-1]}}, w.im};
    br = {{(SW+1){b.re[SW-1]}}, b.re};
    bi = {{(SW+1){b.im[SW-1]}}, b.im};
    pr = (wr * br - wi * bi) >>> FRAC;
    pi = (wr * bi + wi * br) >>> FRAC;
    o.re = pr[SW:0];
    o.im = pi[SW:0];
    return o;
  endfunction

  // (a +/- p) >>> 1 with saturation to SW bits
  function automatic logic signed [SW-1:0] half_sat(input logic signed [SW-1:0] a,
                                                    input logic signed [SW:0] p,
                                                    input logic sub);
    logic signed [SW+1:0] ax, px, s;
    int v;
    ax = {{2{a[SW-1]}}, a};
    px = {p[SW], p};
    s  = sub ? (ax - px) : (ax + px);
    v  = int'(s >>> 1);
    if (v > MAXV) v = MAXV;
    else if (v < -MAXV - 1) v = -MAXV - 1;
    return v[SW-1:0];
  endfunction
endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom import fft_pkg::*; #(
  parameter int LOG2N = 6
) (
  input  logic [LOG2N-2:0] k,
  output cplx_t            w
);
  localparam int  HALF   = 1 << (LOG2N - 1);
  localparam real TWO_PI = 6.283185307179586;

  cplx_t tbl [HALF];

  for (genvar i = 0; i < HALF; i++) begin : g_tw
    localparam real ANG = TWO_PI * $itor(i) / $itor(2 * HALF);
    localparam int  CV  = int'($itor(MAXV) * $cos(ANG));
    localparam int  SV  = int'(-$itor(MAXV) * $sin(ANG));
    assign tbl[i] = {CV[SW-1:0], SV[SW-1:0]};
  end

  assign w = tbl[k];
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen import fft_pkg::*; #(
  parameter int LOG2N = 6,
  parameter int SB    = 3
) (
  input  logic [SB-1:0]    stg,
  input  logic [LOG2N-2:0] bf,
  output logic [LOG2N-1:0] ia,
  output logic [LOG2N-1:0] ib,
  output logic [LOG2N-2:0] tw_idx
);
  always_comb begin
    int sh, grp, off, base, hi, rv;
    sh     = LOG2N - 1 - int'(stg);
    grp    = int'(bf) >> sh;
    off    = int'(bf) & ((1 << sh) - 1);
    base   = (grp << (sh + 1)) | off;
    hi     = base | (1 << sh);
    rv     = bitrev(grp, LOG2N - 1);
    ia     = base[LOG2N-1:0];
    ib     = hi[LOG2N-1:0];
    tw_idx = rv[LOG2N-2:0];
  end
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly import fft_pkg::*; (
  input  logic  clk,
  input  logic  en,
  input  cplx_t a,
  input  cplx_t b,
  input  cplx_t w,
  output cplx_t y0,
  output cplx_t y1
);
  cplx_t a_q;
  prod_t p_q;

  always_ff @(posedge clk) begin
    if (en) begin
      a_q <= a;
      p_q <= cmul_floor(w, b);
    end
  end

  always_comb begin
    y0.re = half_sat(a_q.re, p_q.re, 1'b0);
    y0.im = half_sat(a_q.im, p_q.im, 1'b0);
    y1.re = half_sat(a_q.re, p_q.re, 1'b1);
    y1.im = half_sat(a_q.im, p_q.im, 1'b1);
  end
endmodule

// File: rtl/fft_iter_core.sv
module fft_iter_core import fft_pkg::*; #(
  parameter int LOG2N = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 ld_en,
  input  logic [LOG2N-1:0]     ld_addr,
  input  logic signed [SW-1:0] ld_re,
  input  logic signed [SW-1:0] ld_im,
  input  logic [LOG2N-1:0]     rd_addr,
  output logic signed [SW-1:0] rd_re,
  output logic signed [SW-1:0] rd_im,
  output logic                 busy,
  output logic                 done
);
  localparam int N  = 1 << LOG2N;
  localparam int SB = (LOG2N > 1) ? $clog2(LOG2N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_MUL, S_WR} st_t;

  st_t              st;
  logic [SB-1:0]    stg;
  logic [LOG2N-2:0] bf;
  logic [LOG2N-1:0] ia, ib;
  logic [LOG2N-2:0] tw_idx;
  cplx_t            tw, opa, opb, y0, y1;
  cplx_t            mem [N];

  // named internal events
  logic bf_last, stg_last, rd_fire, mul_fire, wr_fire;
  assign bf_last  = &bf;
  assign stg_last = (stg == SB'(LOG2N - 1));
  assign rd_fire  = (st == S_RD);
  assign mul_fire = (st == S_MUL);
  assign wr_fire  = (st == S_WR);
  assign busy     = (st != S_IDLE);

  fft_addr_gen #(.LOG2N(LOG2N), .SB(SB)) u_addr (
    .stg(stg), .bf(bf), .ia(ia), .ib(ib), .tw_idx(tw_idx)
  );

  fft_twiddle_rom #(.LOG2N(LOG2N)) u_rom (.k(tw_idx), .w(tw));

  fft_butterfly u_bfly (
    .clk(clk), .en(mul_fire), .a(opa), .b(opb), .w(tw), .y0(y0), .y1(y1)
  );

  // stage / index controller
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      stg  <= '0;
      bf   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_RD;
          stg <= '0;
          bf  <= '0;
        end
        S_RD:  st <= S_MUL;
        S_MUL: st <= S_WR;
        S_WR: begin
          st <= S_RD;
          bf <= bf + 1'b1;
          if (bf_last) begin
            if (stg_last) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              stg <= stg + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // sample memory: operand fetch, write-back, host load
  always_ff @(posedge clk) begin
    if (rd_fire) begin
      opa <= mem[ia];
      opb <= mem[ib];
    end
    if (wr_fire) begin
      mem[ia] <= y0;
      mem[ib] <= y1;
    end else if (!busy && ld_en) begin
      mem[ld_addr] <= '{re: ld_re, im: ld_im};
    end
  end

  // host unload port, frozen while busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_re <= '0;
      rd_im <= '0;
    end else if (!busy) begin
      rd_re <= mem[rd_addr].re;
      rd_im <= mem[rd_addr].im;
    end
  end

  // assertions
  p_pair_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((int'(ib) - int'(ia)) == (1 << (LOG2N - 1 - int'(stg)))));

  p_stage_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(stg) <= LOG2N - 1));

  p_wb_after_mul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(mul_fire));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_unload_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rd_re) && $stable(rd_im)));
endmodule

// File: tb/sim_fft_iter_core.sv
`timescale 1ns/1ps
module sim_fft_iter_core;
  localparam int L   = 4;
  localparam int N   = 1 << L;
  localparam int TOT = 3 * L * (N / 2);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ld_en = 1'b0;
  logic [L-1:0] ld_addr = '0, rd_addr = '0;
  logic signed [15:0] ld_re = '0, ld_im = '0;
  logic signed [15:0] rd_re, rd_im;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  bit ended = 1'b0;
  int xr [N];
  int xi [N];
  int unsigned seed = 32'h1ace_b00c;

  always #2.5 clk = ~clk;

  fft_iter_core #(.LOG2N(L)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_re(ld_re), .ld_im(ld_im), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  function automatic int brev(input int v, input int w);
    int r = 0;
    for (int i = 0; i < w; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int nextr();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return int'(seed & 32'hffff) - 32768;
  endfunction

  // behavioural reference transform, group by group
  task automatic model();
    for (int s = 0; s < L; s++) begin
      int h = N >> (s + 1);
      for (int g = 0; g < (1 << s); g++) begin
        int  k  = brev(g, s) * h;
        real an = 6.283185307179586 * k / N;
        int  wr = rnd(32767.0 * $cos(an));
        int  wi = rnd(-32767.0 * $sin(an));
        for (int j = 0; j < h; j++) begin
          int p = g * 2 * h + j;
          int q = p + h;
          longint tr = (longint'(wr) * xr[q] - longint'(wi) * xi[q]) >>> 15;
          longint ti = (longint'(wr) * xi[q] + longint'(wi) * xr[q]) >>> 15;
          int ar = xr[p], ai = xi[p];
          xr[p] = sat((ar + int'(tr)) >>> 1);
          xi[p] = sat((ai + int'(ti)) >>> 1);
          xr[q] = sat((ar - int'(tr)) >>> 1);
          xi[q] = sat((ai - int'(ti)) >>> 1);
        end
      end
    end
  endtask

  task automatic load_all();
    for (int a = 0; a < N; a++) begin
      ld_en = 1'b1; ld_addr = L'(a); ld_re = 16'(xr[a]); ld_im = 16'(xi[a]);
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic compare_all(input string req);
    for (int a = 0; a < N; a++) begin
      rd_addr = L'(a);
      @(negedge clk);
      chk(req, $sformatf("re[%0d]", a), int'(rd_re), xr[a]);
      chk(req, $sformatf("im[%0d]", a), int'(rd_im), xi[a]);
    end
  endtask

  // start, then check busy/done every cycle; optional pokes while busy (R8)
  task automatic run(input bit poke);
    int hold_re, hold_im;
    rd_addr = '0;
    @(negedge clk);
    hold_re = int'(rd_re); hold_im = int'(rd_im);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < TOT; c++) begin
      chk("R3", "busy during run", int'(busy), 1);
      chk("R7", "done during run", int'(done), 0);
      if (poke) begin
        if (c == 4) begin ld_en = 1'b1; ld_addr = '0; ld_re = 16'sd777; ld_im = -16'sd777; rd_addr = 4'd5; end
        if (c == 9) ld_en = 1'b0;
        chk("R8", "rd_re frozen", int'(rd_re), hold_re);
        chk("R8", "rd_im frozen", int'(rd_im), hold_im);
      end
      @(negedge clk);
    end
    chk("R3", "busy after last stage", int'(busy), 0);
    chk("R7", "done pulse", int'(done), 1);
    @(negedge clk);
    chk("R7", "done single cycle", int'(done), 0);
    model();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3", "busy in reset", int'(busy), 0);
    chk("R7", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: load and read back while idle
    ld_en = 1'b1; ld_addr = 4'd5; ld_re = 16'sd1234; ld_im = -16'sd567;
    @(negedge clk);
    ld_en = 1'b0; rd_addr = 4'd5;
    @(negedge clk);
    chk("R1", "load readback re", int'(rd_re), 1234);
    chk("R1", "load readback im", int'(rd_im), -567);

    // impulse
    for (int a = 0; a < N; a++) begin xr[a] = 0; xi[a] = 0; end
    xr[0] = 20000;
    load_all(); run(1'b0); compare_all("R4");

    // constant input
    for (int a = 0; a < N; a++) begin xr[a] = 10000; xi[a] = -3000; end
    load_all(); run(1'b0); compare_all("R2");

    // single complex tone at bin 3 (R9)
    for (int a = 0; a < N; a++) begin
      xr[a] = rnd(12000.0 * $cos(6.283185307179586 * 3 * a / N));
      xi[a] = rnd(12000.0 * $sin(6.283185307179586 * 3 * a / N));
    end
    load_all(); run(1'b0); compare_all("R9");
    begin
      int best = -1, bestv = -1;
      for (int a = 0; a < N; a++) begin
        int m;
        rd_addr = L'(a);
        @(negedge clk);
        m = (rd_re < 0 ? -int'(rd_re) : int'(rd_re)) + (rd_im < 0 ? -int'(rd_im) : int'(rd_im));
        if (m > bestv) begin bestv = m; best = a; end
      end
      chk("R9", "tone peak address", best, brev(3, L));
    end

    // pseudo-random full scale, pokes while busy (R8, R5)
    for (int a = 0; a < N; a++) begin xr[a] = nextr(); xi[a] = nextr(); end
    load_all(); run(1'b1); compare_all("R5");

    // all most-negative values: saturation corner (R6)
    for (int a = 0; a < N; a++) begin xr[a] = -32768; xi[a] = -32768; end
    load_all(); run(1'b0); compare_all("R6");

    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule